// File: doc/BRIEF.md
# USB host functional state controller

This block keeps the two-bit functional state of a USB host controller and the reset, wakeup and interrupt-steering behaviour attached to it. Host software moves the controller between its four states through a write port. A hardware reset and a software reset each force an entry state of their own. The only move the controller makes by itself is from suspend to resume, when a downstream port reports resume signalling.

When the controller enters operation, the block holds off the start-of-frame enable until a fixed number of millisecond ticks have passed. It also drives a root-hub reset request and a remote-wakeup line. A resume-detected event is steered to either the normal interrupt line or the system-management interrupt line. Two configuration bits, wakeup-connected and interrupt-routing, are kept across a software reset and are lost only on a hardware reset.

Top module: `hc_func_state`

## Requirements
- R1: While `rst_ni` is low and on its release, the state is reset (`state_o` = 2'b00), `sof_en_o` is 0, and the wakeup-enable, wakeup-connected, interrupt-routing and resume-status bits are all 0.
- R2: The state codes are 00 reset, 01 resume, 10 operational and 11 suspend. A pulse on `host_wr_i` loads `host_state_i` into `state_o` at the next clock edge. A host write takes priority over an autonomous move in the same cycle.
- R3: A pulse on `sw_rst_i` puts the state in suspend at the next edge and clears the wakeup-enable and resume-status bits. It wins over a host write in the same cycle.
- R4: Without a host write or a software reset, the state changes only from suspend to resume, and only on a `resume_det_i` pulse. In every other state `resume_det_i` leaves the state unchanged.
- R5: After the state enters operational from another state, a tick is counted at each edge where `tick_1ms_i` is high and the state was already operational before that edge. `sof_en_o` rises at the edge of counted tick number `SOF_DELAY_MS`+1 (2 ticks by default), because the first tick only marks a partial millisecond.
- R6: `sof_en_o` is 0 in every cycle in which the state is not operational. A host write of operational while already operational does not restart the delay. Leaving operational and entering it again restarts the delay from zero.
- R7: `rh_reset_o` is high exactly while the state is reset. This includes the state forced by a hardware reset.
- R8: A `resume_det_i` pulse sets the resume status in any state, and a `resume_clr_i` pulse clears it. Set wins over clear. `remote_wake_o` is high only while both the wakeup enable and the resume status are set.
- R9: The wakeup-enable bit has no effect on `irq_o` or `smi_o`.
- R10: While the resume status is set, `smi_o` is high if interrupt routing is 1, and `irq_o` is high if it is 0. Both are low while the status is clear.
- R11: A `cfg_we_i` pulse loads the three configuration bits. Wakeup-connected and interrupt-routing are cleared by a hardware reset and keep their value across a software reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst_i | input | 1 | Software reset pulse |
| host_wr_i | input | 1 | Host write strobe for the state field |
| host_state_i | input | 2 | State value written by the host |
| cfg_we_i | input | 1 | Write strobe for the configuration bits |
| cfg_wake_en_i | input | 1 | New wakeup-enable value |
| cfg_wake_conn_i | input | 1 | New wakeup-connected value |
| cfg_irq_route_i | input | 1 | New interrupt-routing value |
| resume_det_i | input | 1 | Downstream resume detected, one-cycle pulse |
| resume_clr_i | input | 1 | Clears the resume status |
| tick_1ms_i | input | 1 | Millisecond tick, one-cycle pulse |
| state_o | output | 2 | Current functional state |
| sof_en_o | output | 1 | Start-of-frame generation enable |
| rh_reset_o | output | 1 | Root-hub and downstream reset request |
| remote_wake_o | output | 1 | Remote wakeup to the host system |
| irq_o | output | 1 | Normal interrupt line |
| smi_o | output | 1 | System-management interrupt line |
| wake_en_o | output | 1 | Wakeup-enable bit |
| wake_conn_o | output | 1 | Wakeup-connected bit |
| irq_route_o | output | 1 | Interrupt-routing bit |

## Verification
The bench aims a tick at the very edge where the state enters operational. A design that counted that tick would raise the start-of-frame enable one millisecond early. It also re-enters operational after a short visit elsewhere, where a counter that was not cleared would fire too soon, and it rewrites operational while already operational, where a careless restart would drop an enable that was already on. It collides a software reset with a host write, and a host write with a resume pulse in suspend, to catch wrong priority. It also issues a software reset with both retained bits set, which exposes a design that clears them on the wrong kind of reset.

// File: rtl/hc_state_pkg.sv
package hc_state_pkg;
  typedef enum logic [1:0] {
    HS_RESET   = 2'b00,
    HS_RESUME  = 2'b01,
    HS_OPER    = 2'b10,
    HS_SUSPEND = 2'b11
  } hc_state_e;
endpackage

// File: rtl/hc_state_fsm.sv
module hc_state_fsm
  import hc_state_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sw_rst_i,
  input  logic      host_wr_i,
  input  hc_state_e host_state_i,
  input  logic      resume_det_i,
  output hc_state_e state_q_o,
  output hc_state_e state_d_o
);
  hc_state_e state_q, state_d;

  // priority: software reset, host write, self move suspend->resume
  always_comb begin
    state_d = state_q;
    if (sw_rst_i)                                   state_d = HS_SUSPEND;
    else if (host_wr_i)                             state_d = host_state_i;
    else if (state_q == HS_SUSPEND && resume_det_i) state_d = HS_RESUME;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= HS_RESET;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
endmodule

// File: rtl/hc_sof_delay.sv
module hc_sof_delay #(
  parameter int unsigned DELAY_MS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oper_q_i,
  input  logic oper_d_i,
  input  logic tick_i,
  output logic sof_en_o
);
  localparam int unsigned CntW = $clog2(DELAY_MS + 2);
  localparam logic [CntW-1:0] LastCnt = CntW'(DELAY_MS);

  logic [CntW-1:0] cnt_q;
  logic            sof_q;

  // counting only while operational on both sides of the edge; the first
  // counted tick is a partial millisecond, so DELAY_MS+1 ticks are needed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sof_q <= 1'b0;
    end else if (!(oper_q_i && oper_d_i)) begin
      cnt_q <= '0;
      sof_q <= 1'b0;
    end else if (tick_i && !sof_q) begin
      if (cnt_q == LastCnt) sof_q <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sof_en_o = sof_q;
endmodule

// File: rtl/hc_wake_irq.sv
module hc_wake_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_rst_i,
  input  logic cfg_we_i,
  input  logic cfg_wake_en_i,
  input  logic cfg_wake_conn_i,
  input  logic cfg_irq_route_i,
  input  logic resume_det_i,
  input  logic resume_clr_i,
  output logic remote_wake_o,
  output logic irq_o,
  output logic smi_o,
  output logic wake_en_o,
  output logic wake_conn_o,
  output logic irq_route_o
);
  logic wake_en_q, wake_conn_q, route_q, sts_q;

  // bits lost on either reset kind
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_en_q <= 1'b0;
      sts_q     <= 1'b0;
    end else if (sw_rst_i) begin
      wake_en_q <= 1'b0;
      sts_q     <= 1'b0;
    end else begin
      if (cfg_we_i)          wake_en_q <= cfg_wake_en_i;
      if (resume_det_i)      sts_q     <= 1'b1;
      else if (resume_clr_i) sts_q     <= 1'b0;
    end
  end

  // bits lost on hardware reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_conn_q <= 1'b0;
      route_q     <= 1'b0;
    end else if (cfg_we_i) begin
      wake_conn_q <= cfg_wake_conn_i;
      route_q     <= cfg_irq_route_i;
    end
  end

  assign remote_wake_o = wake_en_q & sts_q;
  assign irq_o         = sts_q & ~route_q;
  assign smi_o         = sts_q & route_q;
  assign wake_en_o     = wake_en_q;
  assign wake_conn_o   = wake_conn_q;
  assign irq_route_o   = route_q;
endmodule

// File: rtl/hc_func_state.sv
module hc_func_state
  import hc_state_pkg::*;
#(
  parameter int unsigned SOF_DELAY_MS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_rst_i,
  input  logic       host_wr_i,
  input  logic [1:0] host_state_i,
  input  logic       cfg_we_i,
  input  logic       cfg_wake_en_i,
  input  logic       cfg_wake_conn_i,
  input  logic       cfg_irq_route_i,
  input  logic       resume_det_i,
  input  logic       resume_clr_i,
  input  logic       tick_1ms_i,
  output logic [1:0] state_o,
  output logic       sof_en_o,
  output logic       rh_reset_o,
  output logic       remote_wake_o,
  output logic       irq_o,
  output logic       smi_o,
  output logic       wake_en_o,
  output logic       wake_conn_o,
  output logic       irq_route_o
);
  hc_state_e state_q, state_d;

  hc_state_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sw_rst_i     (sw_rst_i),
    .host_wr_i    (host_wr_i),
    .host_state_i (hc_state_e'(host_state_i)),
    .resume_det_i (resume_det_i),
    .state_q_o    (state_q),
    .state_d_o    (state_d)
  );

  hc_sof_delay #(.DELAY_MS(SOF_DELAY_MS)) u_sof (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .oper_q_i (state_q == HS_OPER),
    .oper_d_i (state_d == HS_OPER),
    .tick_i   (tick_1ms_i),
    .sof_en_o (sof_en_o)
  );

  hc_wake_irq u_wake (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sw_rst_i        (sw_rst_i),
    .cfg_we_i        (cfg_we_i),
    .cfg_wake_en_i   (cfg_wake_en_i),
    .cfg_wake_conn_i (cfg_wake_conn_i),
    .cfg_irq_route_i (cfg_irq_route_i),
    .resume_det_i    (resume_det_i),
    .resume_clr_i    (resume_clr_i),
    .remote_wake_o   (remote_wake_o),
    .irq_o           (irq_o),
    .smi_o           (smi_o),
    .wake_en_o       (wake_en_o),
    .wake_conn_o     (wake_conn_o),
    .irq_route_o     (irq_route_o)
  );

  assign state_o    = state_q;
  assign rh_reset_o = (state_q == HS_RESET);
endmodule

// File: rtl/hc_func_state_chk.sv
module hc_func_state_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sw_rst_i,
  input logic       host_wr_i,
  input logic [1:0] host_state_i,
  input logic       cfg_we_i,
  input logic       resume_det_i,
  input logic       tick_1ms_i,
  input logic [1:0] state_o,
  input logic       sof_en_o,
  input logic       remote_wake_o,
  input logic       irq_o,
  input logic       smi_o,
  input logic       wake_en_o,
  input logic       wake_conn_o,
  input logic       irq_route_o
);
  p_host_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && !sw_rst_i) |=> state_o == $past(host_state_i));

  p_sw_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (state_o == 2'b11 && !wake_en_o));

  p_no_self_move_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && !sw_rst_i && state_o != 2'b11) |=> $stable(state_o));

  p_self_resume_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && !sw_rst_i && state_o == 2'b11 && resume_det_i) |=> state_o == 2'b01);

  p_sof_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sof_en_o) |-> $past(tick_1ms_i));

  p_sof_off_at_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b10 && $past(state_o) != 2'b10) |-> !sof_en_o);

  p_sof_only_oper_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_en_o |-> state_o == 2'b10);

  p_wake_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remote_wake_o |-> wake_en_o);

  p_one_irq_line_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && smi_o));

  p_smi_routed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> irq_route_o);

  p_keep_on_sw_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rst_i && !cfg_we_i) |=> ($stable(wake_conn_o) && $stable(irq_route_o)));
endmodule

bind hc_func_state hc_func_state_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sw_rst_i      (sw_rst_i),
  .host_wr_i     (host_wr_i),
  .host_state_i  (host_state_i),
  .cfg_we_i      (cfg_we_i),
  .resume_det_i  (resume_det_i),
  .tick_1ms_i    (tick_1ms_i),
  .state_o       (state_o),
  .sof_en_o      (sof_en_o),
  .remote_wake_o (remote_wake_o),
  .irq_o         (irq_o),
  .smi_o         (smi_o),
  .wake_en_o     (wake_en_o),
  .wake_conn_o   (wake_conn_o),
  .irq_route_o   (irq_route_o)
);

// File: tb/hc_func_state_tb_top.sv
`timescale 1ns/1ps
module hc_func_state_tb_top;
  localparam int DLY = 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw_rst = 0, host_wr = 0, cfg_we = 0, c_wen = 0, c_conn = 0, c_route = 0;
  logic res_det = 0, res_clr = 0, tick = 0;
  logic [1:0] host_st = 2'b00;
  logic [1:0] state;
  logic sof, rh, wake, irq, smi, wen, conn, route;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hc_func_state #(.SOF_DELAY_MS(DLY)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sw_rst_i(sw_rst), .host_wr_i(host_wr),
    .host_state_i(host_st), .cfg_we_i(cfg_we), .cfg_wake_en_i(c_wen),
    .cfg_wake_conn_i(c_conn), .cfg_irq_route_i(c_route), .resume_det_i(res_det),
    .resume_clr_i(res_clr), .tick_1ms_i(tick), .state_o(state), .sof_en_o(sof),
    .rh_reset_o(rh), .remote_wake_o(wake), .irq_o(irq), .smi_o(smi),
    .wake_en_o(wen), .wake_conn_o(conn), .irq_route_o(route)
  );

  // reference model
  int m_state = 0, m_cnt = 0;
  bit m_sof = 0, m_sts = 0, m_wen = 0, m_conn = 0, m_route = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_cnt = 0; m_sof = 0; m_sts = 0; m_wen = 0; m_conn = 0; m_route = 0;
    end else begin
      int nxt;
      nxt = m_state;
      if (sw_rst) nxt = 3;
      else if (host_wr) nxt = int'(host_st);
      else if (m_state == 3 && res_det) nxt = 1;
      if (m_state == 2 && nxt == 2) begin
        if (tick && !m_sof) begin
          m_cnt++;
          if (m_cnt == DLY + 1) m_sof = 1;
        end
      end else begin
        m_cnt = 0; m_sof = 0;
      end
      if (sw_rst) begin m_sts = 0; m_wen = 0; end
      else begin
        if (res_det) m_sts = 1; else if (res_clr) m_sts = 0;
        if (cfg_we) m_wen = c_wen;
      end
      if (cfg_we) begin m_conn = c_conn; m_route = c_route; end
      m_state = nxt;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk("R2 state", int'(state), m_state);
      chk("R5 sof", int'(sof), int'(m_sof));
      chk("R7 rh_reset", int'(rh), int'(m_state == 0));
      chk("R8 wake", int'(wake), int'(m_wen && m_sts));
      chk("R10 irq", int'(irq), int'(m_sts && !m_route));
      chk("R10 smi", int'(smi), int'(m_sts && m_route));
      chk("R11 conn", int'(conn), int'(m_conn));
      chk("R11 route", int'(route), int'(m_route));
      chk("R3 wake_en", int'(wen), int'(m_wen));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_state(logic [1:0] v, bit tk = 0);
    host_wr = 1; host_st = v; tick = tk;
    @(negedge clk);
    host_wr = 0; tick = 0;
  endtask

  task automatic pulse_tick();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic pulse_res();
    res_det = 1; @(negedge clk); res_det = 0;
  endtask

  task automatic cfg(bit we_v, bit cn, bit rt);
    cfg_we = 1; c_wen = we_v; c_conn = cn; c_route = rt;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic hw_reset();
    rst_ni = 0; idle(2); rst_ni = 1; idle(1);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    // R1: reset values while held
    chk("R1 state in reset", int'(state), 0);
    chk("R1 sof in reset", int'(sof), 0);
    chk("R7 rh_reset in reset", int'(rh), 1);
    rst_ni = 1; idle(1);
    chk("R1 conn after reset", int'(conn), 0);

    // R4: resume pulse in reset state does not move state
    pulse_res();
    chk("R4 no move from reset", int'(state), 0);
    chk("R9 irq with wake_en off", int'(irq), 1);
    chk("R8 no wake without enable", int'(wake), 0);
    cfg(1, 0, 0);
    chk("R8 wake with enable", int'(wake), 1);
    chk("R9 irq unchanged by enable", int'(irq), 1);
    res_clr = 1; @(negedge clk); res_clr = 0;
    chk("R8 status cleared", int'(wake), 0);

    // R5: tick at entry edge not counted, two counted ticks needed
    wr_state(2'b10, 1);
    chk("R7 rh off in oper", int'(rh), 0);
    idle(3);
    pulse_tick();
    chk("R5 sof after one tick", int'(sof), 0);
    idle(2);
    pulse_tick();
    chk("R5 sof after two ticks", int'(sof), 1);

    // R6: rewrite oper keeps sof, leave drops it, re-entry restarts
    wr_state(2'b10);
    chk("R6 rewrite keeps sof", int'(sof), 1);
    wr_state(2'b11);
    chk("R6 sof off in suspend", int'(sof), 0);
    pulse_res();
    chk("R4 suspend to resume", int'(state), 1);
    wr_state(2'b10);
    pulse_tick();
    wr_state(2'b01);
    wr_state(2'b10);
    pulse_tick();
    chk("R6 restart after re-entry", int'(sof), 0);
    pulse_tick();
    chk("R6 sof after restart", int'(sof), 1);

    // R10/R11/R3: routing and retention across software reset
    cfg(1, 1, 1);
    pulse_res();
    chk("R10 smi when routed", int'(smi), 1);
    chk("R10 irq off when routed", int'(irq), 0);
    sw_rst = 1; host_wr = 1; host_st = 2'b10;
    @(negedge clk);
    sw_rst = 0; host_wr = 0;
    chk("R3 sw reset wins", int'(state), 3);
    chk("R3 wake_en cleared", int'(wen), 0);
    chk("R11 conn kept", int'(conn), 1);
    chk("R11 route kept", int'(route), 1);
    chk("R3 sof off", int'(sof), 0);

    // R2: host write beats self move in suspend
    host_wr = 1; host_st = 2'b00; res_det = 1;
    @(negedge clk);
    host_wr = 0; res_det = 0;
    chk("R2 write beats resume", int'(state), 0);

    // R11: hardware reset clears retained bits
    hw_reset();
    chk("R11 conn cleared by hw", int'(conn), 0);
    chk("R11 route cleared by hw", int'(route), 0);
    chk("R1 state after hw reset", int'(state), 0);

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      host_wr = ($urandom_range(0, 9) == 0);
      host_st = 2'($urandom_range(0, 3));
      sw_rst  = ($urandom_range(0, 60) == 0);
      res_det = ($urandom_range(0, 12) == 0);
      res_clr = ($urandom_range(0, 8) == 0);
      tick    = ($urandom_range(0, 4) == 0);
      cfg_we  = ($urandom_range(0, 20) == 0);
      c_wen   = 1'($urandom_range(0, 1));
      c_conn  = 1'($urandom_range(0, 1));
      c_route = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    host_wr = 0; sw_rst = 0; res_det = 0; res_clr = 0; tick = 0; cfg_we = 0;
    idle(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule